// File: doc/BRIEF.md
# Slot-Numbered Backplane Address Decoder

This block sits on one expansion card in a backplane where every card position owns two address windows. The first is a 256 MB card window whose top address nibble equals the position number. The second is a 16 MB position window whose top nibble is all ones and whose next nibble equals the position number. The decoder takes the bus address, an address strobe and the card's 4-bit position number. It reports, one clock later, which of the two windows the access fell into.

A small control word is written over a local port. It carries a pairing option, a store-and-forward enable and a collision flag. With pairing enabled, the least significant bit of the position number is left out of both comparisons, so the card claims the windows of two neighbouring positions. A separate capture-check input marks the address ranges that a host processor card keeps for itself in positions 2, 4 and 6. While that input is high, an access in one of those ranges raises a capture flag in place of a card-window hit.

The address, strobe and capture-check inputs are plain qualifiers sampled at every edge. There is no handshake and no back-pressure.

Top module: `slot_addr_decoder`

## Requirements
- R1: With `bus_strobe` high at a rising edge, `board_hit` is 1 after that edge exactly when `bus_addr[31:28]` equals `slot_id` and is not 0xF, unless R7 applies.
- R2: With `bus_strobe` high at a rising edge, `slot_hit` is 1 after that edge exactly when `bus_addr[31:28]` is 0xF and `bus_addr[27:24]` equals `slot_id`.
- R3: When control bit 28 (pairing) is 1, both comparisons use only bits 3..1 of the nibble against bits 3..1 of `slot_id`. For example, position 2 then also answers for 3, and position 5 also answers for 4.
- R4: A nibble of 0xF never matches a position, and a `slot_id` of 0xF never matches anything, whether pairing is on or off.
- R5: When `bus_strobe` is low at a rising edge, `board_hit`, `slot_hit` and `captured` are all 0 after it.
- R6: `board_hit` and `slot_hit` are never 1 together.
- R7: With `cap_chk_en` high, an address whose top nibble is 2, 4 or 6 and whose bits 27..12 are 0x200C, or whose bits 27..24 are 0x1, sets `captured` after the edge and forces `board_hit` to 0. This applies whatever `slot_id` is.
- R8: With `cap_chk_en` low, `captured` stays 0 and the captured ranges decode as in R1.
- R9: The control word resets to 0x0800_0000. Only bits 28, 27 and 26 are writable, and every other bit reads 0. A write through `ctl_wr_en` is visible on `ctl_rd_data` and in decoding after the edge that takes it.
- R10: During and right after reset, all three decode outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 32 | Bus address |
| bus_strobe | input | 1 | Address strobe, qualifies `bus_addr` |
| slot_id | input | 4 | Position number of this card |
| cap_chk_en | input | 1 | Enables flagging of host-captured ranges |
| ctl_wr_en | input | 1 | Local control write enable |
| ctl_wr_data | input | 32 | Local control write data |
| ctl_rd_data | output | 32 | Current control word |
| board_hit | output | 1 | Access fell in this card's 256 MB window |
| slot_hit | output | 1 | Access fell in this card's 16 MB window |
| captured | output | 1 | Access fell in a host-captured range |

## Verification
Every position number is swept with pairing off and on. For each one the first and last byte of both its own windows are probed, along with the neighbouring position whose number differs only in the low bit. This separates an exact comparison from a paired one, and it catches a card window wrongly claimed by an all-ones nibble. The captured ranges are probed exactly on their edges and one address outside them, with the check input on and off, and from a card whose position differs from the captured one. Idle cycles between accesses show that nothing is reported without the strobe.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int ADDR_W  = 32;
  localparam int SLOT_W  = 4;
  localparam int CTL_W   = 32;

  localparam int PAIR_BIT  = 28;
  localparam int SFWD_BIT  = 27;
  localparam int RMCOL_BIT = 26;

  localparam logic [CTL_W-1:0] CTL_MASK  =
    (CTL_W'(1) << PAIR_BIT) | (CTL_W'(1) << SFWD_BIT) | (CTL_W'(1) << RMCOL_BIT);
  localparam logic [CTL_W-1:0] CTL_RESET = CTL_W'(1) << SFWD_BIT;

  localparam logic [SLOT_W-1:0] SLOT_TOP = '1;

  localparam logic [15:0] CAP_SLOT_SET = 16'h0054;
  localparam logic [15:0] CAP_PAGE     = 16'h200C;
  localparam logic [3:0]  CAP_SEG      = 4'h1;

  typedef struct packed {
    logic board;
    logic slot;
    logic capt;
  } dec_t;
endpackage

// File: rtl/sad_ctrl_reg.sv
module sad_ctrl_reg
  import sad_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  output logic [CTL_W-1:0] ctl_q,
  output logic             pair_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RESET;
    else if (wr_en) ctl_q <= wr_data & CTL_MASK;
  end

  assign pair_en = ctl_q[PAIR_BIT];

  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctl_q == ($past(wr_data) & CTL_MASK))); // R9
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctl_q)); // R9
endmodule

// File: rtl/sad_slot_cmp.sv
module sad_slot_cmp
  import sad_pkg::*;
(
  input  logic [SLOT_W-1:0] field,
  input  logic [SLOT_W-1:0] slot_id,
  input  logic              pair_en,
  output logic              match
);
  logic legal;
  logic upper_eq;
  logic low_eq;

  always_comb begin
    legal    = (field != SLOT_TOP) && (slot_id != SLOT_TOP);
    upper_eq = (field[SLOT_W-1:1] == slot_id[SLOT_W-1:1]);
    low_eq   = (field[0] == slot_id[0]);
    match    = legal && upper_eq && (pair_en || low_eq);
  end
endmodule

// File: rtl/sad_capture_chk.sv
module sad_capture_chk
  import sad_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              chk_en,
  output logic              in_capture
);
  logic [15:0] slot_sel;
  logic        page_hit;
  logic        seg_hit;

  for (genvar g = 0; g < 16; g++) begin : g_slot
    assign slot_sel[g] = CAP_SLOT_SET[g] && (addr[ADDR_W-1 -: SLOT_W] == SLOT_W'(g));
  end

  always_comb begin
    page_hit   = (addr[ADDR_W-SLOT_W-1 -: 16] == CAP_PAGE);
    seg_hit    = (addr[ADDR_W-SLOT_W-1 -: SLOT_W] == CAP_SEG);
    in_capture = chk_en && (|slot_sel) && (page_hit || seg_hit);
  end
endmodule

// File: rtl/slot_addr_decoder.sv
module slot_addr_decoder
  import sad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_strobe,
  input  logic [SLOT_W-1:0] slot_id,
  input  logic              cap_chk_en,
  input  logic              ctl_wr_en,
  input  logic [CTL_W-1:0]  ctl_wr_data,
  output logic [CTL_W-1:0]  ctl_rd_data,
  output logic              board_hit,
  output logic              slot_hit,
  output logic              captured
);
  logic              pair_en;
  logic              board_match;
  logic              slot_match;
  logic              in_capture;
  logic [SLOT_W-1:0] top_nib;
  logic [SLOT_W-1:0] sub_nib;
  dec_t              dec_d;
  dec_t              dec_q;

  assign top_nib = bus_addr[ADDR_W-1 -: SLOT_W];
  assign sub_nib = bus_addr[ADDR_W-SLOT_W-1 -: SLOT_W];

  sad_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_wr_en),
    .wr_data (ctl_wr_data),
    .ctl_q   (ctl_rd_data),
    .pair_en (pair_en)
  );

  sad_slot_cmp u_board_cmp (
    .field   (top_nib),
    .slot_id (slot_id),
    .pair_en (pair_en),
    .match   (board_match)
  );

  sad_slot_cmp u_slot_cmp (
    .field   (sub_nib),
    .slot_id (slot_id),
    .pair_en (pair_en),
    .match   (slot_match)
  );

  sad_capture_chk u_capt (
    .addr       (bus_addr),
    .chk_en     (cap_chk_en),
    .in_capture (in_capture)
  );

  always_comb begin
    dec_d.capt  = bus_strobe && in_capture;
    dec_d.board = bus_strobe && board_match && !in_capture;
    dec_d.slot  = bus_strobe && (top_nib == SLOT_TOP) && slot_match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dec_q <= '0;
    else        dec_q <= dec_d;
  end

  assign board_hit = dec_q.board;
  assign slot_hit  = dec_q.slot;
  assign captured  = dec_q.capt;

  AST_QUIET_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_strobe |=> !(board_hit || slot_hit || captured)); // R5
  AST_WINDOWS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(board_hit && slot_hit)); // R6
  AST_BOARD_NOT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && top_nib == SLOT_TOP) |=> !board_hit); // R4
  AST_EXACT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && !pair_en && top_nib != slot_id) |=> !board_hit); // R1
  AST_CAPT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_chk_en |=> !captured); // R8
  AST_CAPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    captured |-> !board_hit); // R7
endmodule

// File: tb/slot_addr_decoder_tb.sv
module slot_addr_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_strobe = 1'b0;
  logic [3:0]  slot_id = '0;
  logic        cap_chk_en = 1'b0;
  logic        ctl_wr_en = 1'b0;
  logic [31:0] ctl_wr_data = '0;
  logic [31:0] ctl_rd_data;
  logic        board_hit, slot_hit, captured;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit pair_m = 1'b0;

  typedef struct {
    logic [2:0] exp;
    string      tag;
  } item_t;
  item_t exp_q[$];

  always #5 clk = ~clk;

  slot_addr_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_strobe(bus_strobe),
    .slot_id(slot_id), .cap_chk_en(cap_chk_en), .ctl_wr_en(ctl_wr_en),
    .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
    .board_hit(board_hit), .slot_hit(slot_hit), .captured(captured)
  );

  function automatic bit nib_eq(logic [3:0] a, logic [3:0] s, bit pr);
    if (a == 4'hF || s == 4'hF) return 1'b0;
    if (pr) return a[3:1] == s[3:1];
    return a == s;
  endfunction

  // board, slot, captured
  function automatic logic [2:0] model(logic [31:0] a, logic [3:0] s, bit pr, bit cap);
    bit c, b, sl;
    c  = cap && (a[31:28] == 4'h2 || a[31:28] == 4'h4 || a[31:28] == 4'h6) &&
         (a[27:12] == 16'h200C || a[27:24] == 4'h1);
    b  = nib_eq(a[31:28], s, pr) && !c;
    sl = (a[31:28] == 4'hF) && nib_eq(a[27:24], s, pr);
    return {b, sl, c};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] a, string tag);
    @(negedge clk);
    bus_addr   = a;
    bus_strobe = 1'b1;
    exp_q.push_back('{model(a, slot_id, pair_m, cap_chk_en), tag});
  endtask

  task automatic idle();
    @(negedge clk);
    bus_strobe = 1'b0;
    bus_addr   = 32'h2200C000;
    exp_q.push_back('{3'b000, "R5"});
  endtask

  task automatic ctl_write(logic [31:0] d);
    @(negedge clk);
    bus_strobe  = 1'b0;
    ctl_wr_en   = 1'b1;
    ctl_wr_data = d;
    @(negedge clk);
    ctl_wr_en   = 1'b0;
    pair_m      = d[28];
  endtask

  // monitor: results appear after the edge that samples the strobe
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        check({board_hit, slot_hit, captured} == it.exp, it.tag,
              {29'b0, board_hit, slot_hit, captured}, {29'b0, it.exp});
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    check({board_hit, slot_hit, captured} == 3'b000, "R10 in reset",
          {29'b0, board_hit, slot_hit, captured}, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ctl_rd_data == 32'h0800_0000, "R9 reset value", ctl_rd_data, 32'h0800_0000);
    check({board_hit, slot_hit, captured} == 3'b000, "R10 after reset",
          {29'b0, board_hit, slot_hit, captured}, 32'h0);

    ctl_write(32'hFFFF_FFFF);
    check(ctl_rd_data == 32'h1C00_0000, "R9 write mask", ctl_rd_data, 32'h1C00_0000);
    ctl_write(32'h0000_0000);
    check(ctl_rd_data == 32'h0, "R9 clear", ctl_rd_data, 32'h0);

    // sweep of every position, pairing off then on
    for (int pr = 0; pr < 2; pr++) begin
      ctl_write(pr ? 32'h1000_0000 : 32'h0);
      for (int s = 0; s < 16; s++) begin
        logic [3:0] sv;
        sv = 4'(s);
        @(negedge clk);
        bus_strobe = 1'b0;
        slot_id    = sv;
        apply({sv, 28'h0000000}, pr ? "R3 card window low" : "R1 card window low");
        apply({sv, 28'hFFFFFFF}, pr ? "R3 card window high" : "R1 card window high");
        apply({sv ^ 4'h1, 28'h0000000}, pr ? "R3 paired neighbour card" : "R1 neighbour card");
        apply({sv - 4'h1, 28'hFFFFFFF}, "R1 card below");
        apply({4'hF, sv, 24'h000000}, pr ? "R3 pos window low" : "R2 pos window low");
        apply({4'hF, sv, 24'hFFFFFF}, pr ? "R3 pos window high" : "R2 pos window high");
        apply({4'hF, sv ^ 4'h1, 24'h000000}, pr ? "R3 paired neighbour pos" : "R2 neighbour pos");
        apply({4'hF, 4'hF, 24'h000000}, "R4 top nibble pos");
        apply({4'hF, 28'hFFFFFFF}, "R4 top card window");
        idle();
      end
    end

    // captured ranges
    ctl_write(32'h0);
    @(negedge clk);
    slot_id    = 4'h2;
    cap_chk_en = 1'b1;
    apply(32'h2200C000, "R7 page first");
    apply(32'h2200CFFF, "R7 page last");
    apply(32'h2200BFFF, "R7 below page");
    apply(32'h2200D000, "R7 above page");
    apply(32'h21000000, "R7 segment first");
    apply(32'h21FFFFFF, "R7 segment last");
    apply(32'h22000000, "R7 after segment");
    apply(32'h4200C800, "R7 other position");
    apply(32'h61234567, "R7 position six");
    apply(32'h3200C000, "R7 odd position free");
    idle();
    @(negedge clk);
    slot_id = 4'h3;
    apply(32'h31000000, "R7 position three free");
    @(negedge clk);
    bus_strobe = 1'b0;
    slot_id    = 4'h2;
    cap_chk_en = 1'b0;
    apply(32'h2200C000, "R8 page with check off");
    apply(32'h21000000, "R8 segment with check off");
    idle();
    ctl_write(32'h1000_0000);
    @(negedge clk);
    cap_chk_en = 1'b1;
    slot_id    = 4'h3;
    apply(32'h2200C010, "R7 captured under pairing");
    apply(32'h22000000, "R3 paired card hit");
    idle();
    idle();

    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule